// File: doc/BRIEF.md
# Two-Dimensional Strided Address Generator

This block turns one accepted transfer request into a series of per-row memory commands that together cover a rectangular region. A request carries a start address, the row length in bytes minus one, the number of rows minus one, a row stride, and a cyclic flag. The generator emits one address/length command per row to a memory-side bus master. Each row begins one stride beyond the start of the row before it. Because the stride is separate from the row length, a gap can be skipped between rows. When the last row's command has been taken, a one-cycle done pulse follows. One instance serves the read side of a channel and a second, independent instance serves the write side.

Addresses, strides and lengths are expected to be multiples of the wider bus width, which is 2^ALIGN_BITS bytes. The generator treats the low ALIGN_BITS bits of the start address and of the stride as zero. It forces the same low bits of the length-minus-one field to ones. The row length field is LEN_W bits wide.

Both the request and the command interfaces use valid/ready handshakes. A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is high only while the generator is idle and enabled. A command is held with stable address and length while cmd_valid is high and cmd_ready is low. It is consumed on an edge where both are high, and the consumer may stall for any number of cycles. The level input enable is a plain control pin. Dropping it removes cmd_valid in the same cycle and returns the generator to idle at the next edge, without a done pulse. In cyclic mode the region is replayed from the start address after every pass until enable is dropped.

Top module: `stride_walker`

## Requirements
- R1: After reset, cmd_valid and done are low, and req_ready equals enable.
- R2: A request is accepted only on an edge with req_valid and req_ready both high. From the next cycle until the transfer ends, req_ready is low and cmd_valid is high.
- R3: The first command of a pass carries the start address. Every command carries the programmed row length minus one on cmd_len_m1.
- R4: A row count field of N produces N+1 commands per pass, so a row count field of 0 gives a single-row transfer.
- R5: Each command after the first in a pass has the address of the previous command plus the stride, taken modulo 2^ADDR_W.
- R6: While cmd_valid is high, cmd_ready is low and enable is high, the next cycle shows the same cmd_valid, cmd_addr and cmd_len_m1.
- R7: done is high for the cycle after the edge that accepts the last row of a pass, and low at all other times. A non-cyclic transfer is then idle, with req_ready high.
- R8: With the cyclic flag set (req_cyclic = 1), the command after the last row repeats the start address, and done pulses at the end of every pass.
- R9: With enable low, cmd_valid is low in the same cycle. The generator is idle after the next edge and issues no done pulse, and the aborted request is not resumed.
- R10: The low ALIGN_BITS bits of cmd_addr are always zero, because the same bits of the start address and the stride are treated as zero. The low ALIGN_BITS bits of cmd_len_m1 are always one.
- R11: While enable is low, req_ready is low and an offered request is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Level enable; low aborts and holds idle |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Generator idle and able to take a request |
| req_addr | input | ADDR_W | Start address of the region |
| req_xlen_m1 | input | LEN_W | Row length in bytes minus one |
| req_ylen_m1 | input | ROWS_W | Number of rows minus one |
| req_stride | input | ADDR_W | Byte distance between row starts |
| req_cyclic | input | 1 | Replay the region after each pass |
| cmd_valid | output | 1 | Row command available |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_addr | output | ADDR_W | Row start address |
| cmd_len_m1 | output | LEN_W | Row length in bytes minus one |
| done | output | 1 | One-cycle pulse after the last row of a pass |

## Verification
The tests cover several region shapes:
- A single row separates the row-count handling from address stepping.
- A four-row region with a stride larger than the row length, fed with stalls on cmd_ready, shows that rows step by the stride and not by the length, and that a command holds under back-pressure.
- A region that crosses the top of the address space checks the modulo wrap.
- Misaligned start, stride and length values show the low-bit treatment.
- A cyclic region run over two passes, and a non-cyclic region aborted after one row, tell a replay apart from a restart with fresh state.
- A request offered while enable is low checks that it is ignored.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_EMIT = 1'b1
  } walk_state_e;
endpackage

// File: rtl/walk_rows.sv
// Remaining-row down counter; last is high on the final row of a pass.
module walk_rows #(
  parameter int ROWS_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ROWS_W-1:0] load_val,
  input  logic              step,
  output logic              last
);
  logic [ROWS_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= load_val;
    else if (step) left_q <= left_q - 1'b1;
  end

  assign last = (left_q == '0);
endmodule

// File: rtl/walk_base.sv
// Row base address register: captures the aligned start and stride, steps by the stride, rewinds on restart.
module walk_base #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              restart,
  input  logic              advance,
  input  logic [ADDR_W-1:0] start_in,
  input  logic [ADDR_W-1:0] stride_in,
  output logic [ADDR_W-1:0] row_addr
);
  localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << ALIGN_BITS;

  logic [ADDR_W-1:0] start_q, stride_q, base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      stride_q <= '0;
      base_q   <= '0;
    end else if (capture) begin
      start_q  <= start_in & KEEP;
      stride_q <= stride_in & KEEP;
      base_q   <= start_in & KEEP;
    end else if (restart) begin
      base_q   <= start_q;
    end else if (advance) begin
      base_q   <= base_q + stride_q;
    end
  end

  assign row_addr = base_q;
endmodule

// File: rtl/stride_walker.sv
module stride_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int ROWS_W     = 12,
  parameter int ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_xlen_m1,
  input  logic [ROWS_W-1:0] req_ylen_m1,
  input  logic [ADDR_W-1:0] req_stride,
  input  logic              req_cyclic,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len_m1,
  output logic              done
);
  walk_state_e       state_q;
  logic [LEN_W-1:0]  xlen_q;
  logic [ROWS_W-1:0] ylen_q;
  logic              cyc_q;
  logic              done_q;
  logic              fire_req, fire_cmd, row_last;
  logic              wrap, rows_load;
  logic [ROWS_W-1:0] rows_val;

  assign req_ready = enable && (state_q == WALK_IDLE);
  assign cmd_valid = enable && (state_q == WALK_EMIT);
  assign fire_req  = req_valid && req_ready;
  assign fire_cmd  = cmd_valid && cmd_ready;
  assign wrap      = fire_cmd && row_last && cyc_q;
  assign rows_load = fire_req || wrap;
  assign rows_val  = fire_req ? req_ylen_m1 : ylen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      xlen_q  <= '0;
      ylen_q  <= '0;
      cyc_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire_cmd && row_last;
      if (fire_req) begin
        xlen_q <= req_xlen_m1;
        ylen_q <= req_ylen_m1;
        cyc_q  <= req_cyclic;
      end
      if (!enable)
        state_q <= WALK_IDLE;
      else if (fire_req)
        state_q <= WALK_EMIT;
      else if (fire_cmd && row_last && !cyc_q)
        state_q <= WALK_IDLE;
    end
  end

  walk_rows #(.ROWS_W(ROWS_W)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rows_load),
    .load_val (rows_val),
    .step     (fire_cmd && !row_last),
    .last     (row_last)
  );

  walk_base #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (fire_req),
    .restart   (wrap),
    .advance   (fire_cmd && !row_last),
    .start_in  (req_addr),
    .stride_in (req_stride),
    .row_addr  (cmd_addr)
  );

  generate
    if (ALIGN_BITS > 0) begin : g_len_align
      assign cmd_len_m1 = {xlen_q[LEN_W-1:ALIGN_BITS], {ALIGN_BITS{1'b1}}};
    end else begin : g_len_plain
      assign cmd_len_m1 = xlen_q;
    end
  endgenerate

  assign done = done_q;
endmodule

// File: rtl/stride_walker_chk.sv
module stride_walker_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int ALIGN_BITS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_len_m1,
  input logic              done
);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && enable) |=>
      (!enable || (cmd_valid && $stable(cmd_addr) && $stable(cmd_len_m1))));

  // R9
  gated_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !cmd_valid);

  // R2
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  // R7
  done_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid && cmd_ready));

  // R11
  ready_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !req_ready);

  generate
    if (ALIGN_BITS > 0) begin : g_align
      // R10
      addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr[ALIGN_BITS-1:0] == '0));
      // R10
      len_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (&cmd_len_m1[ALIGN_BITS-1:0]));
    end
  endgenerate
endmodule

bind stride_walker stride_walker_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .req_ready  (req_ready),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_addr   (cmd_addr),
  .cmd_len_m1 (cmd_len_m1),
  .done       (done)
);

// File: tb/stride_walker_test.sv
`timescale 1ns/1ps
module stride_walker_test;
  localparam int AW = 32, LW = 16, RW = 12, AB = 3;
  localparam logic [AW-1:0] KEEP = {AW{1'b1}} << AB;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
  logic req_valid = 1'b0, req_cyclic = 1'b0, cmd_ready = 1'b0;
  logic [AW-1:0] req_addr = '0, req_stride = '0;
  logic [LW-1:0] req_xlen_m1 = '0;
  logic [RW-1:0] req_ylen_m1 = '0;
  logic req_ready, cmd_valid, done;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len_m1;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  stride_walker #(.ADDR_W(AW), .LEN_W(LW), .ROWS_W(RW), .ALIGN_BITS(AB)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
    .req_stride(req_stride), .req_cyclic(req_cyclic),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len_m1(cmd_len_m1), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic submit(input logic [AW-1:0] a, input logic [LW-1:0] x, input logic [RW-1:0] y,
                        input logic [AW-1:0] s, input logic c);
    @(negedge clk);
    req_addr = a; req_xlen_m1 = x; req_ylen_m1 = y; req_stride = s; req_cyclic = c;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready && cmd_valid, "R2 busy after accept", {req_ready, cmd_valid}, 2'b01);
  endtask

  // Consume nrows commands and compare each with the model.
  task automatic expect_rows(input logic [AW-1:0] a, input logic [AW-1:0] s, input logic [LW-1:0] x,
                             input int y, input int nrows, input bit stall, input bit cyc);
    for (int r = 0; r < nrows; r++) begin
      int pos = r % (y + 1);
      logic [AW-1:0] ea = (a & KEEP) + AW'(pos) * (s & KEEP);
      logic [LW-1:0] el = x | LW'((1 << AB) - 1);
      int wait_n = 0;
      bit lastp = (pos == y);
      @(negedge clk);
      while (!cmd_valid && wait_n < 50) begin @(negedge clk); wait_n++; end
      if (stall) begin
        @(negedge clk);
        check(cmd_valid && cmd_addr == ea, "R6 held under stall", cmd_addr, ea);
      end
      if (pos == 0) check(cmd_addr == ea, "R3 first row address", cmd_addr, ea);
      else          check(cmd_addr == ea, "R5 stepped row address", cmd_addr, ea);
      check(cmd_len_m1 == el, "R3 R10 row length", cmd_len_m1, el);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      check(done == lastp, lastp ? "R7 R8 done after last row" : "R4 R7 no done mid pass", done, lastp);
      if (lastp && !cyc) check(req_ready && !cmd_valid, "R4 R7 idle after pass", {req_ready, cmd_valid}, 2'b10);
      if (lastp && cyc)  check(!req_ready, "R8 cyclic stays busy", req_ready, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!cmd_valid && !done && req_ready, "R1 reset state", {cmd_valid, done, req_ready}, 3'b001);
  endtask

  task automatic t_one_row;
    submit(32'h0000_1000, 16'd63, '0, 32'h0, 1'b0);
    expect_rows(32'h0000_1000, 32'h0, 16'd63, 0, 1, 1'b0, 1'b0);
  endtask

  task automatic t_gap_region;
    submit(32'h2000_0040, 16'd31, 12'd3, 32'h100, 1'b0);
    expect_rows(32'h2000_0040, 32'h100, 16'd31, 3, 4, 1'b1, 1'b0);
  endtask

  task automatic t_wrap;
    submit(32'hFFFF_FF00, 16'd15, 12'd2, 32'h80, 1'b0);
    expect_rows(32'hFFFF_FF00, 32'h80, 16'd15, 2, 3, 1'b0, 1'b0);
  endtask

  task automatic t_align;
    submit(32'h0000_3005, 16'h21, 12'd1, 32'h43, 1'b0);
    expect_rows(32'h0000_3005, 32'h43, 16'h21, 1, 2, 1'b0, 1'b0);
    check(cmd_len_m1 == 16'h27, "R10 forced length bits", cmd_len_m1, 16'h27);
  endtask

  task automatic t_cyclic;
    submit(32'h0000_5000, 16'd15, 12'd2, 32'h20, 1'b1);
    expect_rows(32'h0000_5000, 32'h20, 16'd15, 2, 6, 1'b0, 1'b1);
    @(negedge clk);
    check(cmd_valid && cmd_addr == 32'h5000, "R8 third pass restarts", cmd_addr, 32'h5000);
    enable = 1'b0;
    #1 check(!cmd_valid, "R9 cmd dropped with enable", cmd_valid, 0);
    @(negedge clk);
    enable = 1'b1;
    #1 check(req_ready && !cmd_valid, "R9 idle after abort", {req_ready, cmd_valid}, 2'b10);
  endtask

  task automatic t_abort;
    submit(32'h0000_6000, 16'd7, 12'd3, 32'h10, 1'b0);
    expect_rows(32'h0000_6000, 32'h10, 16'd7, 3, 1, 1'b0, 1'b0);
    enable = 1'b0;
    #1 check(!cmd_valid, "R9 cmd gated at once", cmd_valid, 0);
    @(negedge clk);
    check(!done && !req_ready, "R9 no done on abort", {done, req_ready}, 2'b00);
    enable = 1'b1;
    #1 check(req_ready && !cmd_valid, "R9 not resumed", {req_ready, cmd_valid}, 2'b10);
    submit(32'h0000_7000, 16'd7, '0, 32'h0, 1'b0);
    expect_rows(32'h0000_7000, 32'h0, 16'd7, 0, 1, 1'b0, 1'b0);
  endtask

  task automatic t_disabled_req;
    @(negedge clk);
    enable = 1'b0;
    req_addr = 32'h8000; req_ylen_m1 = '0; req_cyclic = 1'b0; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!req_ready, "R11 not ready while disabled", req_ready, 0);
    end
    req_valid = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    check(!cmd_valid && req_ready, "R11 request was ignored", {cmd_valid, req_ready}, 2'b01);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_one_row();
    t_gap_region();
    t_wrap();
    t_align();
    t_cyclic();
    t_abort();
    t_disabled_req();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule